// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches recent virtual-to-physical page mappings for a processor request port. Each lookup presents a 32-bit virtual address, an access kind and a privilege mode. The 20-bit virtual page number is compared against every resident entry at once. One cycle later the block answers with one of three results: a physical address, a miss (the page-walk unit must fetch the mapping), or a fault code. Each entry holds a complete page table entry: frame number, present flag, and read/write/execute permissions.

The page-walk side loads mappings through a fill port. Software-driven maintenance uses two ports: an invalidate port removes one page after its protection changes, and a flush port empties the whole buffer on a context switch. A fill goes to the lowest-numbered free slot. When every slot is occupied, a round-robin pointer chooses the entry to evict. A fill for a page that is already resident rewrites that entry in place.

Top module: `xlat_buffer`

## Requirements
- R1: A lookup presented with `req_valid` high at one rising edge produces `resp_valid` high, with its result, right after the next rising edge. `resp_valid` is low in every cycle that follows no request.
- R2: On a hit whose entry is present and permits the access, the response is: `resp_paddr` = frame number in bits 31:12, request offset unchanged in bits 11:0, `resp_fault` = 2'b00, `resp_miss` = 0.
- R3: Access codes are 2'b00 read, 2'b01 write and 2'b10 execute. Fill permissions are `fill_perm` = {execute, write, read}. A present hit whose permission bit for the access is clear returns fault 2'b10, with a zero address.
- R4: A hit on an entry whose present flag is clear returns fault 2'b01, with a zero address.
- R5: In user mode (`req_user` = 1), any address at or above 0xC0000000 returns fault 2'b11, whatever the buffer holds. Kernel mode may reach the whole space, and the user-mode check does not apply below that boundary.
- R6: A lookup that matches no resident entry returns `resp_miss` = 1, fault 2'b00 and address zero.
- R7: A fill whose page is already resident overwrites that entry, so the page never appears twice.
- R8: An invalidate removes only the named page's entry; other entries keep hitting.
- R9: A flush empties every entry. A fill in the same cycle as a flush is discarded.
- R10: A fill takes the lowest-numbered free slot. If no slot is free, it evicts the slot under a round-robin pointer. The pointer starts at slot 0 and advances by one after each such eviction.
- R11: A lookup sees the contents from before any fill, invalidate or flush in its own cycle. An invalidate and a fill of the same page in one cycle leave the page absent.
- R12: After reset, `resp_valid` is low and no entry is resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_miss | output | 1 | No resident entry for the page |
| resp_fault | output | 2 | 00 none, 01 page, 10 protection, 11 privilege |
| resp_paddr | output | 32 | Physical address on a clean hit, else zero |
| fill_valid | input | 1 | Load an entry |
| fill_vpn | input | 20 | Page number of the entry being loaded |
| fill_frame | input | 20 | Frame number of the entry being loaded |
| fill_present | input | 1 | Present flag of the entry being loaded |
| fill_perm | input | 3 | {execute, write, read} permissions |
| inval_valid | input | 1 | Remove one page |
| inval_vpn | input | 20 | Page number to remove |
| flush | input | 1 | Remove all entries |

## Verification
The interesting collisions are a lookup landing in the same cycle as a fill, an invalidate or a flush. The bench drives such pairs on a single edge. A lookup issued together with a fill of its own page must report a miss, and a repeat one cycle later must hit. A fill paired with an invalidate of the same page, or with a flush, must leave that page missing. Replacement is judged by filling the buffer completely, evicting, freeing one slot, and then reading back which pages still hit.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int FRAME_W = 20;

    // lowest page number that user mode may not touch (0xC0000000 >> 12)
    localparam logic [VPN_W-1:0] USER_LIMIT_VPN = VPN_W'(20'hC0000);

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_PAGE = 2'b01,
        FLT_PROT = 2'b10,
        FLT_PRIV = 2'b11
    } fault_e;

    typedef struct packed {
        logic               present;
        logic               ex;
        logic               wr;
        logic               rd;
        logic [FRAME_W-1:0] frame;
    } pte_t;

    function automatic logic perm_ok(pte_t p, acc_e a);
        case (a)
            ACC_READ:  return p.rd;
            ACC_WRITE: return p.wr;
            ACC_EXEC:  return p.ex;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/xlat_cam.sv
module xlat_cam
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [ENTRIES-1:0]            used,
    input  logic [VPN_W-1:0]              key,
    output logic [ENTRIES-1:0]            hit
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit[i] = used[i] && (tags[i] == key);
    end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] used,
    input  logic               alloc,
    output logic [ENTRIES-1:0] pick
);

    logic [IDX_W-1:0]   rr_q;
    logic [ENTRIES-1:0] free_pick;
    logic               any_free;

    // lowest-numbered free slot
    always_comb begin
        free_pick = '0;
        any_free  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!used[i] && !any_free) begin
                free_pick[i] = 1'b1;
                any_free     = 1'b1;
            end
        end
    end

    always_comb begin
        pick = free_pick;
        if (!any_free) begin
            pick       = '0;
            pick[rr_q] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (alloc && !any_free) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/xlat_resolve.sv
module xlat_resolve
    import xlat_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    input  acc_e            acc,
    input  logic            user,
    input  logic            hit_any,
    input  pte_t            pte,
    output logic            miss,
    output fault_e          fault,
    output logic [VA_W-1:0] paddr
);

    logic [VPN_W-1:0] vpn;
    assign vpn = vaddr[VA_W-1:OFF_W];

    always_comb begin
        miss  = 1'b0;
        fault = FLT_NONE;
        paddr = '0;
        if (user && (vpn >= USER_LIMIT_VPN)) begin
            fault = FLT_PRIV;
        end else if (!hit_any) begin
            miss = 1'b1;
        end else if (!pte.present) begin
            fault = FLT_PAGE;
        end else if (!perm_ok(pte, acc)) begin
            fault = FLT_PROT;
        end else begin
            paddr = {pte.frame, vaddr[OFF_W-1:0]};
        end
    end

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_acc,
    input  logic        req_user,
    output logic        resp_valid,
    output logic        resp_miss,
    output logic [1:0]  resp_fault,
    output logic [31:0] resp_paddr,
    input  logic        fill_valid,
    input  logic [19:0] fill_vpn,
    input  logic [19:0] fill_frame,
    input  logic        fill_present,
    input  logic [2:0]  fill_perm,
    input  logic        inval_valid,
    input  logic [19:0] inval_vpn,
    input  logic        flush
);

    logic [ENTRIES-1:0]            slot_used;
    logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
    pte_t [ENTRIES-1:0]            pte_q;

    logic [ENTRIES-1:0] look_hit;
    logic [ENTRIES-1:0] fill_hit;
    logic [ENTRIES-1:0] inval_hit;
    logic [ENTRIES-1:0] victim;
    logic [ENTRIES-1:0] fill_sel;
    logic               fill_eff;
    logic               alloc;
    pte_t               hit_pte;
    pte_t               new_pte;

    xlat_cam #(.ENTRIES(ENTRIES)) u_cam_look (
        .tags(tag_q), .used(slot_used), .key(req_vaddr[VA_W-1:OFF_W]), .hit(look_hit)
    );
    xlat_cam #(.ENTRIES(ENTRIES)) u_cam_fill (
        .tags(tag_q), .used(slot_used), .key(fill_vpn), .hit(fill_hit)
    );
    xlat_cam #(.ENTRIES(ENTRIES)) u_cam_inval (
        .tags(tag_q), .used(slot_used), .key(inval_vpn), .hit(inval_hit)
    );

    // a fill is dropped by a same-cycle flush or an invalidate of its own page
    assign fill_eff = fill_valid && !flush && !(inval_valid && (inval_vpn == fill_vpn));
    assign alloc    = fill_eff && !(|fill_hit);
    assign fill_sel = (|fill_hit) ? fill_hit : victim;

    xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst(rst), .used(slot_used), .alloc(alloc), .pick(victim)
    );

    assign new_pte = '{present: fill_present, ex: fill_perm[2], wr: fill_perm[1],
                       rd: fill_perm[0], frame: fill_frame};

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                slot_used[i] <= 1'b0;
            end else if (inval_valid && inval_hit[i]) begin
                slot_used[i] <= 1'b0;
            end else if (fill_eff && fill_sel[i]) begin
                slot_used[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_eff && fill_sel[i]) begin
                tag_q[i] <= fill_vpn;
                pte_q[i] <= new_pte;
            end
        end
    end

    always_comb begin
        hit_pte = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (look_hit[i]) hit_pte = hit_pte | pte_q[i];
        end
    end

    logic            rs_miss;
    fault_e          rs_fault;
    logic [VA_W-1:0] rs_paddr;

    xlat_resolve u_resolve (
        .vaddr(req_vaddr), .acc(acc_e'(req_acc)), .user(req_user),
        .hit_any(|look_hit), .pte(hit_pte),
        .miss(rs_miss), .fault(rs_fault), .paddr(rs_paddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_miss  <= 1'b0;
            resp_fault <= FLT_NONE;
            resp_paddr <= '0;
        end else begin
            resp_valid <= req_valid;
            resp_miss  <= req_valid && rs_miss;
            resp_fault <= req_valid ? rs_fault : FLT_NONE;
            resp_paddr <= req_valid ? rs_paddr : '0;
        end
    end

endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk #(
    parameter int ENTRIES = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [31:0]        req_vaddr,
    input logic               req_user,
    input logic               resp_valid,
    input logic               resp_miss,
    input logic [1:0]         resp_fault,
    input logic [31:0]        resp_paddr,
    input logic               flush,
    input logic [ENTRIES-1:0] slot_used,
    input logic [ENTRIES-1:0] look_hit
);

    AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid); // R1
    AST_CLEAN_OFFSET: assert property (@(posedge clk) disable iff (rst)
        req_valid ##1 (resp_valid && !resp_miss && resp_fault == 2'b00)
        |-> resp_paddr[11:0] == $past(req_vaddr[11:0])); // R2
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault != 2'b00) |-> (resp_paddr == 32'h0 && !resp_miss)); // R3
    AST_USER_CEILING: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_user && req_vaddr >= 32'hC000_0000) |=> resp_fault == 2'b11); // R5
    AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_miss) |-> (resp_fault == 2'b00 && resp_paddr == 32'h0)); // R6
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(look_hit)); // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> slot_used == '0); // R9

endmodule

bind xlat_buffer xlat_buffer_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_user(req_user), .resp_valid(resp_valid), .resp_miss(resp_miss),
    .resp_fault(resp_fault), .resp_paddr(resp_paddr), .flush(flush),
    .slot_used(slot_used), .look_hit(look_hit)
);

// File: tb/tb_xlat_buffer.sv
`timescale 1ns/1ps
module tb_xlat_buffer;

    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic        resp_valid, resp_miss;
    logic [1:0]  resp_fault;
    logic [31:0] resp_paddr;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_frame = '0;
    logic        fill_present = 1'b0;
    logic [2:0]  fill_perm = '0;
    logic        inval_valid = 1'b0;
    logic [19:0] inval_vpn = '0;
    logic        flush = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    xlat_buffer #(.ENTRIES(N)) dut (.*);

    typedef struct packed {
        logic [3:0]  rq;
        logic [1:0]  op;     // 0 lookup, 1 fill, 2 invalidate, 3 flush
        logic [31:0] addr;
        logic [1:0]  acc;
        logic        user;
        logic [19:0] frame;
        logic [3:0]  flags;  // {present, x, w, r}
        logic        miss;
        logic [1:0]  flt;
        logic [31:0] pa;
    } vec_t;

    localparam int NV = 20;
    localparam logic [99:0] TBL [NV] = '{
        {4'd2, 2'd1, 32'h0001_0000, 2'd0, 1'b0, 20'h0ABCD, 4'b1011, 1'b0, 2'd0, 32'h0},
        {4'd2, 2'd0, 32'h0001_0123, 2'd0, 1'b1, 20'h0,     4'b0000, 1'b0, 2'd0, 32'h0ABCD123}, // R2 read
        {4'd2, 2'd0, 32'h0001_0456, 2'd1, 1'b1, 20'h0,     4'b0000, 1'b0, 2'd0, 32'h0ABCD456}, // R2 write
        {4'd3, 2'd0, 32'h0001_0456, 2'd2, 1'b1, 20'h0,     4'b0000, 1'b0, 2'd2, 32'h0},        // R3 exec denied
        {4'd4, 2'd1, 32'h0002_0000, 2'd0, 1'b0, 20'h12345, 4'b0111, 1'b0, 2'd0, 32'h0},
        {4'd4, 2'd0, 32'h0002_0000, 2'd0, 1'b0, 20'h0,     4'b0000, 1'b0, 2'd1, 32'h0},        // R4
        {4'd5, 2'd0, 32'hC000_0000, 2'd0, 1'b1, 20'h0,     4'b0000, 1'b0, 2'd3, 32'h0},        // R5 no entry
        {4'd5, 2'd1, 32'hC000_0000, 2'd0, 1'b0, 20'h00777, 4'b1001, 1'b0, 2'd0, 32'h0},
        {4'd5, 2'd0, 32'hC000_0FFF, 2'd0, 1'b0, 20'h0,     4'b0000, 1'b0, 2'd0, 32'h00777FFF}, // R5 kernel
        {4'd5, 2'd0, 32'hC000_0FFF, 2'd0, 1'b1, 20'h0,     4'b0000, 1'b0, 2'd3, 32'h0},        // R5 user
        {4'd6, 2'd0, 32'hBFFF_FFFF, 2'd0, 1'b1, 20'h0,     4'b0000, 1'b1, 2'd0, 32'h0},        // R6 below limit
        {4'd7, 2'd1, 32'h0001_0000, 2'd0, 1'b0, 20'h0BEEF, 4'b1100, 1'b0, 2'd0, 32'h0},
        {4'd7, 2'd0, 32'h0001_0004, 2'd2, 1'b0, 20'h0,     4'b0000, 1'b0, 2'd0, 32'h0BEEF004}, // R7
        {4'd7, 2'd0, 32'h0001_0004, 2'd0, 1'b0, 20'h0,     4'b0000, 1'b0, 2'd2, 32'h0},        // R7 old perms gone
        {4'd8, 2'd2, 32'h0001_0000, 2'd0, 1'b0, 20'h0,     4'b0000, 1'b0, 2'd0, 32'h0},
        {4'd8, 2'd0, 32'h0001_0004, 2'd2, 1'b0, 20'h0,     4'b0000, 1'b1, 2'd0, 32'h0},        // R8 removed
        {4'd8, 2'd0, 32'hC000_0010, 2'd1, 1'b0, 20'h0,     4'b0000, 1'b0, 2'd2, 32'h0},        // R8 others kept
        {4'd9, 2'd3, 32'h0,         2'd0, 1'b0, 20'h0,     4'b0000, 1'b0, 2'd0, 32'h0},
        {4'd9, 2'd0, 32'hC000_0010, 2'd0, 1'b0, 20'h0,     4'b0000, 1'b1, 2'd0, 32'h0},        // R9
        {4'd9, 2'd0, 32'h0002_0000, 2'd0, 1'b0, 20'h0,     4'b0000, 1'b1, 2'd0, 32'h0}         // R9
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        req_valid   = 1'b0;
        fill_valid  = 1'b0;
        inval_valid = 1'b0;
        flush       = 1'b0;
    endtask

    task automatic check(int rq, logic miss, logic [1:0] flt, logic [31:0] pa);
        n_chk++;
        if (resp_valid !== 1'b1 || resp_miss !== miss || resp_fault !== flt || resp_paddr !== pa) begin
            n_fail++;
            $display("FAIL R%0d: got v=%b miss=%b fault=%0d pa=%h, expected v=1 miss=%b fault=%0d pa=%h",
                     rq, resp_valid, resp_miss, resp_fault, resp_paddr, miss, flt, pa);
        end
    endtask

    task automatic look(logic [31:0] va, logic [1:0] acc, logic user);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_user = user;
    endtask

    task automatic load(logic [19:0] vpn, logic [19:0] frame, logic pres, logic [2:0] perm);
        fill_valid = 1'b1; fill_vpn = vpn; fill_frame = frame;
        fill_present = pres; fill_perm = perm;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12: idle after reset
        n_chk++;
        if (resp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R12: got resp_valid=%b, expected 0", resp_valid);
        end
        look(32'h0001_0000, 2'd0, 1'b0); step(); check(12, 1'b1, 2'd0, 32'h0); // R12 empty
        // R1: no response in a cycle without a request
        step();
        n_chk++;
        if (resp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got resp_valid=%b, expected 0", resp_valid);
        end

        for (int i = 0; i < NV; i++) begin
            v = vec_t'(TBL[i]);
            case (v.op)
                2'd0: begin
                    look(v.addr, v.acc, v.user);
                    step();
                    check(int'(v.rq), v.miss, v.flt, v.pa);
                end
                2'd1: begin
                    load(v.addr[31:12], v.frame, v.flags[3], v.flags[2:0]);
                    step();
                end
                2'd2: begin
                    inval_valid = 1'b1; inval_vpn = v.addr[31:12];
                    step();
                end
                default: begin
                    flush = 1'b1;
                    step();
                end
            endcase
        end

        // R11: lookup and fill of the same page in one cycle sees the old state
        look(32'h0040_0010, 2'd0, 1'b0); load(20'h00400, 20'h0AAAA, 1'b1, 3'b001); step();
        check(11, 1'b1, 2'd0, 32'h0);
        look(32'h0040_0010, 2'd0, 1'b0); step();
        check(11, 1'b0, 2'd0, 32'h0AAAA010);
        // R11: invalidate beats fill of the same page
        load(20'h00401, 20'h0BBBB, 1'b1, 3'b001); inval_valid = 1'b1; inval_vpn = 20'h00401; step();
        look(32'h0040_1000, 2'd0, 1'b0); step();
        check(11, 1'b1, 2'd0, 32'h0);
        // R9: flush beats a same-cycle fill
        load(20'h00402, 20'h0CCCC, 1'b1, 3'b001); flush = 1'b1; step();
        look(32'h0040_2000, 2'd0, 1'b0); step();
        check(9, 1'b1, 2'd0, 32'h0);
        look(32'h0040_0000, 2'd0, 1'b0); step();
        check(9, 1'b1, 2'd0, 32'h0);

        // R10: fill every slot, then evict by round robin and reuse a freed slot
        for (int k = 0; k < N; k++) begin
            load(20'h00100 + 20'(k), 20'h05000 + 20'(k), 1'b1, 3'b001);
            step();
        end
        look(32'h0010_0000, 2'd0, 1'b0); step();
        check(10, 1'b0, 2'd0, 32'h05000000);
        load(20'h00200, 20'h06000, 1'b1, 3'b001); step();   // evicts slot 0
        look(32'h0010_0000, 2'd0, 1'b0); step();
        check(10, 1'b1, 2'd0, 32'h0);
        look(32'h0020_0008, 2'd0, 1'b0); step();
        check(10, 1'b0, 2'd0, 32'h06000008);
        inval_valid = 1'b1; inval_vpn = 20'h00105; step();
        load(20'h00300, 20'h07000, 1'b1, 3'b001); step();   // takes freed slot 5
        look(32'h0010_1000, 2'd0, 1'b0); step();
        check(10, 1'b0, 2'd0, 32'h05001000);
        look(32'h0030_0000, 2'd0, 1'b0); step();
        check(10, 1'b0, 2'd0, 32'h07000000);
        load(20'h00301, 20'h07001, 1'b1, 3'b001); step();   // evicts slot 1
        look(32'h0010_1000, 2'd0, 1'b0); step();
        check(10, 1'b1, 2'd0, 32'h0);
        look(32'h0010_2000, 2'd0, 1'b0); step();
        check(10, 1'b0, 2'd0, 32'h05002000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule